// File: doc/BRIEF.md
# Floating-Point Status and Exception Unit

This block keeps the floating-point status word that sits beside an arithmetic datapath. After each operation the datapath presents the five IEEE exception flags that operation raised, qualified by a valid strobe. The unit records the flags as the current exceptions. It then either raises a one-cycle trap request, when one of those flags is enabled for trapping, or folds the flags into the sticky accrued field.

The two-bit rounding field of the status word is decoded into a one-hot rounding-mode vector that steers the datapath. Software may overwrite the status word with a load. The load goes through a fixed write mask, so the protected fields keep their contents. The rounding output follows the new value in the cycle after the load.

Top module: `fsr_except_unit`

## Requirements
- R1: After reset the status word is all zero, `trap_req` is low and `rnd_mode` is 4'b0001 (nearest).
- R2: An operation with at least one flag set replaces the current-exception field, status bits 4:0, with the operation's flags. The flag bit order is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0. The new value shows on `fsr_o` one cycle after the strobe, and flags from earlier operations do not remain.
- R3: When the operation's flags AND the enable field (bits 27:23, same bit order) are non-zero, the unit writes 3'b001 into the trap-type field at bits 16:14. In the same cycle that `fsr_o` updates, `trap_req` is high for exactly that one cycle.
- R4: When no enabled flag is raised, the flags are ORed into the accrued field at bits 9:5 (flag bit i goes to bit 5+i), and `trap_req` stays low.
- R5: When a trap is taken, the accrued field keeps its previous value.
- R6: An operation with all flags zero, or an idle cycle, leaves the status word unchanged and raises no trap.
- R7: `rnd_mode` is one-hot, decoded from bits 31:30: 0 gives bit0 (nearest-even), 1 gives bit1 (toward zero), 2 gives bit2 (toward +inf), 3 gives bit3 (toward -inf).
- R8: A load sets the status word to `(ld_data & LOAD_MASK) | (old & ~LOAD_MASK)`. The default mask makes bits 31:30, 27:23 and 9:0 writable. `rnd_mode` reflects the loaded value in the next cycle.
- R9: When a load and an operation arrive in the same cycle, the load takes effect and the operation is dropped, with no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation finished this cycle |
| op_flags | input | 5 | Exception flags of that operation (NV,OF,UF,DZ,NX = 4..0) |
| ld_valid | input | 1 | Software load of the status word |
| ld_data | input | 32 | Value to load, filtered by LOAD_MASK |
| fsr_o | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle floating-point trap request |
| rnd_mode | output | 4 | One-hot rounding mode for the datapath |

## Verification
The bench targets operations whose flags hit an enabled bit while other flags are not enabled. A design that merged the flags into the accrued field anyway, or left the trap-type field clear, is caught there. Back-to-back operations with disjoint flags expose a unit that lets old current-exception bits persist. Loads of all ones show whether the protected trap-type bits can be overwritten. A load that coincides with a trapping operation reveals a wrong priority between the two. Random traffic checked against a bench model covers every rounding value and every mix of flags with the enable field.

// File: rtl/fsr_except_unit.sv
module fsr_except_unit #(
  parameter logic [31:0] LOAD_MASK = 32'hCF80_03FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [4:0]  op_flags,
  input  logic        ld_valid,
  input  logic [31:0] ld_data,
  output logic [31:0] fsr_o,
  output logic        trap_req,
  output logic [3:0]  rnd_mode
);
  localparam logic [2:0] TT_IEEE = 3'b001;

  logic [31:0] fsr_r, fsr_nx;
  logic        trap_r;

  wire [4:0] enables = fsr_r[27:23];
  wire       op_go   = op_valid && !ld_valid && (op_flags != 5'd0);
  wire       hit     = |(op_flags & enables);

  always_comb begin
    fsr_nx = fsr_r;
    if (ld_valid)
      fsr_nx = (ld_data & LOAD_MASK) | (fsr_r & ~LOAD_MASK);
    else if (op_go) begin
      fsr_nx[4:0] = op_flags;
      if (hit) fsr_nx[16:14] = TT_IEEE;
      else     fsr_nx[9:5]   = fsr_r[9:5] | op_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_r  <= '0;
      trap_r <= 1'b0;
    end else begin
      fsr_r  <= fsr_nx;
      trap_r <= op_go && hit;
    end
  end

  always_comb begin
    case (fsr_r[31:30])
      2'd0:    rnd_mode = 4'b0001;
      2'd2:    rnd_mode = 4'b0100;
      2'd3:    rnd_mode = 4'b1000;
      default: rnd_mode = 4'b0010;
    endcase
  end

  assign fsr_o    = fsr_r;
  assign trap_req = trap_r;

  a_r2_cexc_replaced: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ld_valid && op_flags != 5'd0) |=> fsr_o[4:0] == $past(op_flags));

  a_r3_trap_type: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> fsr_o[16:14] == TT_IEEE);

  a_r3_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(op_valid && !ld_valid));

  a_r5_accrued_held: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> fsr_o[9:5] == $past(fsr_o[9:5]));

  a_r6_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid && (!op_valid || op_flags == 5'd0)) |=> ($stable(fsr_o) && !trap_req));

  a_r8_protected: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (fsr_o & ~LOAD_MASK) == ($past(fsr_o) & ~LOAD_MASK));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !trap_req);
endmodule

// File: tb/sim_fsr_except_unit.sv
module sim_fsr_except_unit;
  localparam logic [31:0] MASK = 32'hCF80_03FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, ld_valid = 1'b0;
  logic [4:0] op_flags = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] fsr_o;
  logic trap_req;
  logic [3:0] rnd_mode;

  int total = 0, bad = 0;
  logic [31:0] m_fsr = '0;
  logic m_trap = 1'b0;

  always #2.5 clk = ~clk;

  fsr_except_unit u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
    .ld_valid(ld_valid), .ld_data(ld_data), .fsr_o(fsr_o), .trap_req(trap_req), .rnd_mode(rnd_mode));

  function automatic logic [32:0] model(input logic [31:0] s, input logic ov, input logic [4:0] fl,
                                        input logic lv, input logic [31:0] ld);
    logic [31:0] n = s;
    logic t = 1'b0;
    if (lv) n = (ld & MASK) | (s & ~MASK);
    else if (ov && fl != 0) begin
      n[4:0] = fl;
      if ((fl & s[27:23]) != 0) begin n[16:14] = 3'b001; t = 1'b1; end
      else n[9:5] = s[9:5] | fl;
    end
    return {t, n};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ov, input logic [4:0] fl, input logic lv, input logic [31:0] ld,
                      input string tag);
    logic [32:0] r;
    op_valid = ov; op_flags = fl; ld_valid = lv; ld_data = ld;
    r = model(m_fsr, ov, fl, lv, ld);
    m_trap = r[32]; m_fsr = r[31:0];
    @(negedge clk);
    check({tag, " fsr"}, fsr_o, m_fsr);
    check({tag, " trap"}, {31'd0, trap_req}, {31'd0, m_trap});
    check("R7 rnd", {28'd0, rnd_mode}, {28'd0, 4'b0001 << m_fsr[31:30]});
    op_valid = 1'b0; ld_valid = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fsr", fsr_o, 32'd0);
    check("R1 trap", {31'd0, trap_req}, 32'd0);
    check("R1 rnd", {28'd0, rnd_mode}, 32'd1);

    step(1, 5'b10001, 0, 0, "R2 R4 accrue");
    check("R4 direct", fsr_o, 32'h0000_0231);
    step(1, 5'b00000, 0, 0, "R6 no flags");
    step(1, 5'b00010, 0, 0, "R2 no leak");
    check("R2 direct", {27'd0, fsr_o[4:0]}, 32'd2);
    step(0, 0, 1, 32'hFFFF_FFFF, "R8 load all");
    check("R8 direct", fsr_o, 32'hCF80_03FF);
    check("R7 minus", {28'd0, rnd_mode}, 32'h8);
    step(0, 0, 1, 32'h8400_0000, "R8 load tem");
    check("R7 plus", {28'd0, rnd_mode}, 32'h4);
    step(1, 5'b00100, 0, 0, "R4 masked");
    check("R4 direct2", fsr_o, 32'h8400_0084);
    step(1, 5'b01001, 0, 0, "R3 R5 trap");
    check("R3 direct", fsr_o, 32'h8400_4089);
    check("R3 pulse", {31'd0, trap_req}, 32'd1);
    step(0, 0, 0, 0, "R3 one cycle");
    check("R3 drop", {31'd0, trap_req}, 32'd0);
    step(1, 5'b01000, 1, 32'h4000_0000, "R9 load wins");
    check("R9 direct", fsr_o, 32'h4000_4000);
    check("R7 zero", {28'd0, rnd_mode}, 32'h2);

    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      logic [4:0] f = 5'($urandom);
      if (k == 0)      step(0, 0, 1, $urandom, "R8 rand load");
      else if (k == 1) step(1, f, 1, $urandom, "R9 rand both");
      else if (k == 2) step(0, 0, 0, 0, "R6 rand idle");
      else if (k == 3) step(1, 0, 0, 0, "R6 rand zero");
      else             step(1, f, 0, 0, "R2 R3 R4 R5 rand op");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule